// File: doc/BRIEF.md
# Stereo Audio Serializer

The block takes 32-bit sample words through a ready/valid write port, stores them in a small transmit FIFO, and shifts them out one bit per bit-clock strobe on a serial data line, MSB first. A word-select input sets which slot is on the line: low means left and high means right. A frame begins when word-select falls. At that point the block takes a left/right pair from the FIFO, so the channel order cannot slip. Clock generation is outside the block. The surrounding logic supplies a one-cycle `bit_stb` pulse for each bit period and the word-select level that belongs to it.

At runtime the user selects the sample length (16, 24 or 32 bits), the framing and the justification. With delayed framing the MSB appears one bit period after the word-select change. With left-justified framing it appears in the same bit period as the change. Right justification places the LSB in the last bit of the slot. Slot width is the parameter `SLOT_BITS` (32 or more). Any bit of the slot not covered by the sample is sent as zero. If the FIFO does not hold a full pair at a frame start, the whole frame is sent as zeros and a sticky underflow flag is set. While `enable` is low the line is held at zero and nothing is taken from the FIFO.

Top module: `audio_tx_serializer`

## Requirements
- R1: After reset `sd_out` is 0, `underflow` is 0 and `in_ready` is 1.
- R2: `cfg_wlen` selects the sample length: 0 gives 16 bits, 1 gives 24 bits, 2 gives 32 bits, and the reserved value 3 is treated as 32 bits. The sample occupies the low bits of `in_data`, and bits above the sample length are never sent.
- R3: Data leaves MSB first. With `cfg_delay`=0 the MSB is sent for the strobe at which `ws` changes. With `cfg_delay`=1 it is sent one strobe later. `sd_out` carries the bit for a strobe from the cycle after that strobe.
- R4: With `cfg_rjust`=1 the sample is right-aligned, so its LSB is the last bit of the slot and the leading bits of the slot are zero. In this mode `cfg_delay` has no effect.
- R5: Left-justified samples are followed by zeros up to the end of the `SLOT_BITS`-wide slot.
- R6: `ws`=0 selects the left slot and `ws`=1 the right slot. A frame starts at a strobe where `ws` goes from 1 to 0. At that strobe the block takes the two oldest FIFO words: the first is the left sample and the second is the right sample.
- R7: If the FIFO holds fewer than two words at a frame start, the frame is sent as all zeros, no word is taken, and `underflow` goes to 1 and stays at 1 until reset.
- R8: While `enable`=0, `sd_out` is 0 and no word is taken from the FIFO. Words stored while disabled are sent after enabling.
- R9: A change to `cfg_wlen`, `cfg_delay` or `cfg_rjust` while enabled takes effect at the next frame start, not partway through a frame.
- R10: `in_ready` is 0 exactly when the FIFO holds `FIFO_DEPTH` words. A word offered while `in_ready` is 0 is dropped.
- R11: `sd_out` changes only in the cycle after a strobe, and holds its value between strobes.
- R12: With delayed framing the last bit of the right slot goes out in the first bit period of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Transmit channel enable |
| cfg_wlen | input | 2 | Sample length code |
| cfg_delay | input | 1 | 1 = MSB one bit after the word-select change |
| cfg_rjust | input | 1 | 1 = right-justify the sample in its slot |
| in_data | input | 32 | Sample word, right-aligned |
| in_valid | input | 1 | Sample word offered |
| in_ready | output | 1 | FIFO can accept a word |
| bit_stb | input | 1 | One-cycle pulse per bit period |
| ws | input | 1 | Word-select level: 0 left, 1 right |
| sd_out | output | 1 | Serial data |
| underflow | output | 1 | Sticky: a frame started without a full pair |

## Verification
A vector table runs one complete frame plus the first bit of the following frame for each of several settings. The settings cover delayed and left-justified framing at 16 bits, right justification at 24 bits, full 32-bit words, and the reserved length code. One case also has `cfg_delay` set under right justification. The sample values are asymmetric and carry junk in their upper bits, so the bit-by-bit comparison separates the following faults: a wrong bit order, a one-bit shift, swapped channels, leaking upper bits and a missing zero fill. The bit after the frame separates delayed framing, where the right-channel LSB spills into the next frame, from left-justified framing, where that bit is zero. Directed runs fill the FIFO to capacity, change the length partway through a frame, leave the block disabled through a frame, and start a frame with an empty FIFO.

// File: rtl/audio_tx_serializer.sv
module audio_tx_serializer #(
  parameter int SLOT_BITS  = 32,
  parameter int FIFO_DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [1:0]  cfg_wlen,
  input  logic        cfg_delay,
  input  logic        cfg_rjust,
  input  logic [31:0] in_data,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        bit_stb,
  input  logic        ws,
  output logic        sd_out,
  output logic        underflow
);
  localparam int IDX_W = $clog2(SLOT_BITS) + 1;
  localparam int PTR_W = $clog2(FIFO_DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [IDX_W-1:0] SLOT_N = IDX_W'(SLOT_BITS);
  localparam logic [CNT_W-1:0] FULL_N = CNT_W'(FIFO_DEPTH);

  logic [31:0]      mem [FIFO_DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      left_w, right_w;
  logic [1:0]       wlen_q;
  logic             delay_q, rjust_q;
  logic             ws_q, u_prev, sd_q, udf_q;
  logic [IDX_W-1:0] idx_q;

  wire push      = in_valid && in_ready;
  wire ws_edge   = bit_stb && (ws != ws_q);
  wire frame_go  = bit_stb && enable && ws_q && !ws;
  wire have_pair = cnt >= CNT_W'(2);
  wire pop       = frame_go && have_pair;

  wire [1:0] wl_sel = frame_go ? cfg_wlen  : wlen_q;
  wire       rj_sel = frame_go ? cfg_rjust : rjust_q;
  wire       dl_eff = (frame_go ? cfg_delay : delay_q) && !rj_sel;

  logic [31:0]      word_now;
  logic [IDX_W-1:0] idx_now, wbits;
  logic             u_bit;

  assign in_ready  = cnt != FULL_N;
  assign sd_out    = sd_q;
  assign underflow = udf_q;

  always_comb begin
    if (frame_go)      word_now = have_pair ? mem[rd_ptr] : 32'd0;
    else if (ws)       word_now = right_w;
    else               word_now = left_w;
    if (ws_edge)       idx_now = '0;
    else if (idx_q == SLOT_N) idx_now = idx_q;
    else               idx_now = idx_q + IDX_W'(1);
    case (wl_sel)
      2'd0:    wbits = IDX_W'(16);
      2'd1:    wbits = IDX_W'(24);
      default: wbits = IDX_W'(32);
    endcase
    u_bit = 1'b0;
    if (idx_now < SLOT_N) begin
      if (rj_sel) begin
        if (idx_now >= SLOT_N - wbits)
          u_bit = word_now[5'(SLOT_N - IDX_W'(1) - idx_now)];
      end else if (idx_now < wbits) begin
        u_bit = word_now[5'(wbits - IDX_W'(1) - idx_now)];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0;
      left_w <= '0; right_w <= '0;
      wlen_q <= 2'd0; delay_q <= 1'b0; rjust_q <= 1'b0;
      ws_q <= 1'b1; idx_q <= '0; u_prev <= 1'b0; sd_q <= 1'b0; udf_q <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PTR_W'(1);
      if (pop)  rd_ptr <= rd_ptr + PTR_W'(2);
      cnt <= cnt + CNT_W'(push) - (pop ? CNT_W'(2) : CNT_W'(0));
      if (bit_stb) begin
        ws_q  <= ws;
        idx_q <= idx_now;
      end
      if (!enable) begin
        sd_q <= 1'b0; u_prev <= 1'b0;
        left_w <= '0; right_w <= '0;
        wlen_q <= cfg_wlen; delay_q <= cfg_delay; rjust_q <= cfg_rjust;
      end else if (bit_stb) begin
        u_prev <= u_bit;
        sd_q   <= dl_eff ? u_prev : u_bit;
        if (frame_go) begin
          wlen_q <= cfg_wlen; delay_q <= cfg_delay; rjust_q <= cfg_rjust;
          if (have_pair) begin
            left_w  <= mem[rd_ptr];
            right_w <= mem[rd_ptr + PTR_W'(1)];
          end else begin
            left_w  <= '0;
            right_w <= '0;
            udf_q   <= 1'b1;
          end
        end
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL_N); // R10
  AST_UDF_SET: assert property (@(posedge clk) disable iff (!rst_n) frame_go && !have_pair |=> underflow); // R7
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) underflow |=> underflow); // R7
  AST_SD_OFF: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> !sd_out); // R8
  AST_SD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) enable && !bit_stb |=> $stable(sd_out)); // R11
endmodule

// File: tb/sim_audio_tx_serializer.sv
module sim_audio_tx_serializer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, cfg_delay = 1'b0, cfg_rjust = 1'b0;
  logic [1:0] cfg_wlen = 2'd0;
  logic [31:0] in_data = '0;
  logic in_valid = 1'b0, bit_stb = 1'b0, ws = 1'b1;
  logic in_ready, sd_out, underflow;
  int checks = 0, errors = 0;
  logic prev_u = 1'b0;

  always #10 clk = ~clk;

  audio_tx_serializer u0 (.clk, .rst_n, .enable, .cfg_wlen, .cfg_delay, .cfg_rjust,
    .in_data, .in_valid, .in_ready, .bit_stb, .ws, .sd_out, .underflow);

  // {wlen, delay, rjust, left, right}
  localparam logic [67:0] VEC [6] = '{
    {2'd0, 1'b1, 1'b0, 32'h0000A5C3, 32'h00003C5A},
    {2'd0, 1'b0, 1'b0, 32'hFFFF8001, 32'h12347FFE},
    {2'd1, 1'b0, 1'b1, 32'h55ABCDEF, 32'hAA123456},
    {2'd2, 1'b1, 1'b0, 32'h80000001, 32'hDEADBEEF},
    {2'd3, 1'b0, 1'b0, 32'h0F0F0F0F, 32'hF0F0F0F1},
    {2'd0, 1'b1, 1'b1, 32'h0000BEEF, 32'hFFFF1234}
  };

  task automatic chk(input logic got, input logic exp, input string req, input int pos);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s pos %0d: got %b expected %b", req, pos, got, exp);
    end
  endtask

  function automatic logic exp_u(input logic [31:0] l, input logic [31:0] r,
                                 input logic [1:0] wl, input logic rj, input int i);
    int w, p; logic [31:0] d;
    w = (wl == 2'd0) ? 16 : (wl == 2'd1) ? 24 : 32;
    p = i % 32;
    d = (i >= 32) ? r : l;
    if (rj) return (p >= 32 - w) ? d[31 - p] : 1'b0;
    return (p < w) ? d[w - 1 - p] : 1'b0;
  endfunction

  task automatic push(input logic [31:0] v);
    @(negedge clk); in_data = v; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic strobe(input logic w, output logic got);
    @(negedge clk); ws = w; bit_stb = 1'b1;
    @(negedge clk); bit_stb = 1'b0; got = sd_out;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_frame(input logic [31:0] l, input logic [31:0] r, input logic [1:0] wl,
                           input logic dl, input logic rj, input int chg_at, input string req);
    logic got, u, deff;
    deff = dl && !rj;
    for (int i = 0; i < 64; i++) begin
      if (i == chg_at) cfg_wlen = 2'd2;
      u = exp_u(l, r, wl, rj, i);
      strobe(i >= 32, got);
      chk(got, deff ? prev_u : u, req, i);
      if (i == 5) chk(sd_out, got, "R11", i);
      prev_u = u;
    end
  endtask

  task automatic tail_bit(input logic deff, input string req);
    logic got;
    strobe(1'b0, got);
    chk(got, deff ? prev_u : 1'b0, req, 64);
    prev_u = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic got;
    repeat (3) @(negedge clk);
    chk(sd_out, 1'b0, "R1", 0);
    chk(underflow, 1'b0, "R1", 0);
    chk(in_ready, 1'b1, "R1", 0);
    rst_n = 1'b1;

    for (int v = 0; v < 6; v++) begin
      enable = 1'b0;
      cfg_wlen = VEC[v][67:66]; cfg_delay = VEC[v][65]; cfg_rjust = VEC[v][64];
      push(VEC[v][63:32]); push(VEC[v][31:0]);
      strobe(1'b1, got);
      prev_u = 1'b0;
      enable = 1'b1;
      // R2 R3 R4 R5 R6 per vector
      run_frame(VEC[v][63:32], VEC[v][31:0], VEC[v][67:66], VEC[v][65], VEC[v][64], -1, "R2_R3_R4_R5_R6");
      if (v == 0) chk(underflow, 1'b0, "R7", 0);
      tail_bit(VEC[v][65] && !VEC[v][64], "R12");
      chk(underflow, 1'b1, "R7", 0);
    end

    // R10 fill to capacity, R6 pair order, R9 mid-frame change
    enable = 1'b0; cfg_wlen = 2'd0; cfg_delay = 1'b0; cfg_rjust = 1'b0;
    push(32'h00001111); push(32'h00002222); push(32'h00003333);
    chk(in_ready, 1'b1, "R10", 3);
    push(32'h00004444);
    chk(in_ready, 1'b0, "R10", 4);
    push(32'h00005555);
    strobe(1'b1, got);
    prev_u = 1'b0;
    enable = 1'b1;
    run_frame(32'h00001111, 32'h00002222, 2'd0, 1'b0, 1'b0, 40, "R9");
    chk(in_ready, 1'b1, "R10", 2);
    run_frame(32'h00003333, 32'h00004444, 2'd2, 1'b0, 1'b0, -1, "R6");
    tail_bit(1'b0, "R7");

    // R8 disabled frame keeps line low and leaves the FIFO untouched
    enable = 1'b0; cfg_wlen = 2'd0;
    push(32'h00009A9A); push(32'h00006B6B);
    for (int i = 0; i < 64; i++) begin
      strobe(i >= 32, got);
      if (i % 8 == 0) chk(got, 1'b0, "R8", i);
    end
    strobe(1'b1, got);
    prev_u = 1'b0;
    enable = 1'b1;
    run_frame(32'h00009A9A, 32'h00006B6B, 2'd0, 1'b0, 1'b0, -1, "R8");
    enable = 1'b0;
    @(negedge clk);
    chk(sd_out, 1'b0, "R8", 64);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule